// File: doc/BRIEF.md
# DMA Channel Event Interrupt Unit

This unit collects the interrupt events of one DMA channel. Four of them come from comparing the channel's source and destination byte pointers with the programmed transfer sizes: a pointer can reach the end of its area or the middle of it. The other four arrive as single-cycle pulses from the data mover: cell complete, block complete, transfer abort and address error. Each event latches a sticky flag. Each flag has its own enable bit. A registered request line goes high whenever an enabled flag is pending.

Software sees one 32-bit register through a plain write-enable / read-data port. The enables sit in the third byte and the flags in the low byte, both in the same event order. Software acknowledges an event by writing 0 to its flag. Writing 1 to a flag leaves it as it is. The pointer counters, the data mover and arbitration between channels are outside this unit. The pointers and sizes arrive here as inputs.

Top module: `dma_evt_irq`

## Requirements
- R1: After a synchronous reset, every bit of `reg_rdata` reads 0 and `irq` is 0.
- R2: The event order within a byte is, from bit 7 down to bit 0: source end, source middle, destination end, destination middle, block complete, cell complete, abort, address error. Flags occupy `reg_rdata[7:0]` and enables occupy `reg_rdata[23:16]`, using that order.
- R3: `reg_rdata[31:24]` and `reg_rdata[15:8]` always read 0. Writing ones to those positions changes no readable bit.
- R4: The source end flag (bit 7) sets in the cycle after `src_ptr == src_size` becomes true.
- R5: The source middle flag (bit 6) sets in the cycle after `src_ptr == src_size >> 1` becomes true (the halving rounds down).
- R6: The destination end flag (bit 5) sets in the cycle after `dst_ptr == dst_size` becomes true.
- R7: The destination middle flag (bit 4) sets in the cycle after `dst_ptr == dst_size >> 1` becomes true.
- R8: A pointer flag sets only on the rising edge of its comparison. A comparison that stays true does not set the flag again after software has cleared it.
- R9: A one-cycle pulse on `blk_done_p`, `cell_done_p`, `abort_p` or `addr_err_p` sets flag bit 3, 2, 1 or 0 respectively.
- R10: A register write clears each flag whose `reg_wdata` bit is 0 and keeps each flag whose bit is 1. If a flag's event and a clear of that flag happen in the same cycle, the flag ends up set.
- R11: Every register write loads all eight enables from `reg_wdata[23:16]`. Without a write, the enables hold their value.
- R12: `irq` equals, one cycle later, the OR over all eight positions of flag AND enable. A pending flag whose enable is 0 does not raise `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_ptr | input | PTR_W | Current source byte pointer |
| src_size | input | PTR_W | Programmed source size in bytes |
| dst_ptr | input | PTR_W | Current destination byte pointer |
| dst_size | input | PTR_W | Programmed destination size in bytes |
| blk_done_p | input | 1 | One-cycle pulse: block transfer complete |
| cell_done_p | input | 1 | One-cycle pulse: cell transfer complete |
| abort_p | input | 1 | One-cycle pulse: transfer aborted |
| addr_err_p | input | 1 | One-cycle pulse: address error |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| irq | output | 1 | Registered channel interrupt request |

## Verification
The assertions assume that the event inputs and the write strobe are sampled as plain levels at each clock edge. They also assume that a flag's source is the only thing that can set it. The bench therefore drives every input at the falling edge and holds it through the following rising edge. The pointer and size inputs are random values confined to a small range, so that both the end comparisons and the middle comparisons come true often. Some pointers are held on a matching value across a software clear, which exercises the rule that only a rising edge sets a flag. The pulse inputs are sometimes raised in the same cycle as a write that clears their flag, which exercises the rule that a set wins over a clear.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;

    localparam int EVT_N    = 8;
    localparam int REG_W    = 32;
    localparam int FLAG_LSB = 0;
    localparam int EN_LSB   = 16;
    localparam int SIDES    = 2;

    // Bit position of each event inside the flag byte and the enable byte.
    typedef enum int unsigned {
        EV_ADDR_ERR = 0,
        EV_ABORT    = 1,
        EV_CELL     = 2,
        EV_BLOCK    = 3,
        EV_DST_MID  = 4,
        EV_DST_END  = 5,
        EV_SRC_MID  = 6,
        EV_SRC_END  = 7
    } evt_idx_e;

    typedef logic [EVT_N-1:0] evt_vec_t;

    // Pointer comparison results for one side (source or destination).
    typedef struct packed {
        logic at_end;
        logic at_mid;
    } side_hit_t;

    typedef struct packed {
        side_hit_t src;
        side_hit_t dst;
    } ptr_hits_t;

    // Assembles the register read image from flags and enables.
    function automatic logic [REG_W-1:0] pack_reg(evt_vec_t flags, evt_vec_t enables);
        logic [REG_W-1:0] img;
        img = '0;
        img[FLAG_LSB +: EVT_N] = flags;
        img[EN_LSB   +: EVT_N] = enables;
        return img;
    endfunction

endpackage

// File: rtl/dma_evt_ptr_watch.sv
module dma_evt_ptr_watch
    import dma_evt_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PTR_W-1:0] src_ptr,
    input  logic [PTR_W-1:0] src_size,
    input  logic [PTR_W-1:0] dst_ptr,
    input  logic [PTR_W-1:0] dst_size,
    output ptr_hits_t        hit_rise
);

    logic [PTR_W-1:0] ptr_a  [SIDES];
    logic [PTR_W-1:0] size_a [SIDES];
    side_hit_t        rise_a [SIDES];

    always_comb begin
        ptr_a[0]  = src_ptr;
        size_a[0] = src_size;
        ptr_a[1]  = dst_ptr;
        size_a[1] = dst_size;
    end

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        side_hit_t now_hit;
        side_hit_t last_hit;

        always_comb begin
            now_hit.at_end = (ptr_a[s] == size_a[s]);
            now_hit.at_mid = (ptr_a[s] == (size_a[s] >> 1));
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                last_hit <= '0;
            end else begin
                last_hit <= now_hit;
            end
        end

        always_comb begin
            rise_a[s] = now_hit & ~last_hit;
        end
    end

    always_comb begin
        hit_rise.src = rise_a[0];
        hit_rise.dst = rise_a[1];
    end

endmodule

// File: rtl/dma_evt_flag_bank.sv
module dma_evt_flag_bank
    import dma_evt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  evt_vec_t evt_set,
    input  logic     wr_en,
    input  evt_vec_t wr_flags,
    input  evt_vec_t wr_enables,
    output evt_vec_t flags,
    output evt_vec_t enables
);

    for (genvar i = 0; i < EVT_N; i++) begin : g_bit
        logic keep;

        always_comb begin
            keep = ~wr_en | wr_flags[i];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                flags[i] <= 1'b0;
            end else begin
                flags[i] <= evt_set[i] | (flags[i] & keep);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enables <= '0;
        end else if (wr_en) begin
            enables <= wr_enables;
        end
    end

endmodule

// File: rtl/dma_evt_req.sv
module dma_evt_req
    import dma_evt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  evt_vec_t flags,
    input  evt_vec_t enables,
    output logic     irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else begin
            irq <= |(flags & enables);
        end
    end

endmodule

// File: rtl/dma_evt_irq.sv
module dma_evt_irq
    import dma_evt_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PTR_W-1:0] src_ptr,
    input  logic [PTR_W-1:0] src_size,
    input  logic [PTR_W-1:0] dst_ptr,
    input  logic [PTR_W-1:0] dst_size,
    input  logic             blk_done_p,
    input  logic             cell_done_p,
    input  logic             abort_p,
    input  logic             addr_err_p,
    input  logic             reg_we,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             irq
);

    ptr_hits_t hit_rise;
    evt_vec_t  evt_set;
    evt_vec_t  flags;
    evt_vec_t  enables;

    dma_evt_ptr_watch #(.PTR_W(PTR_W)) u_watch (
        .clk      (clk),
        .rst      (rst),
        .src_ptr  (src_ptr),
        .src_size (src_size),
        .dst_ptr  (dst_ptr),
        .dst_size (dst_size),
        .hit_rise (hit_rise)
    );

    always_comb begin
        evt_set              = '0;
        evt_set[EV_SRC_END]  = hit_rise.src.at_end;
        evt_set[EV_SRC_MID]  = hit_rise.src.at_mid;
        evt_set[EV_DST_END]  = hit_rise.dst.at_end;
        evt_set[EV_DST_MID]  = hit_rise.dst.at_mid;
        evt_set[EV_BLOCK]    = blk_done_p;
        evt_set[EV_CELL]     = cell_done_p;
        evt_set[EV_ABORT]    = abort_p;
        evt_set[EV_ADDR_ERR] = addr_err_p;
    end

    dma_evt_flag_bank u_bank (
        .clk        (clk),
        .rst        (rst),
        .evt_set    (evt_set),
        .wr_en      (reg_we),
        .wr_flags   (reg_wdata[FLAG_LSB +: EVT_N]),
        .wr_enables (reg_wdata[EN_LSB +: EVT_N]),
        .flags      (flags),
        .enables    (enables)
    );

    dma_evt_req u_req (
        .clk     (clk),
        .rst     (rst),
        .flags   (flags),
        .enables (enables),
        .irq     (irq)
    );

    always_comb begin
        reg_rdata = pack_reg(flags, enables);
    end

endmodule

// File: rtl/dma_evt_irq_chk.sv
module dma_evt_irq_chk #(
    parameter int PTR_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [PTR_W-1:0] src_ptr,
    input logic [PTR_W-1:0] src_size,
    input logic [PTR_W-1:0] dst_ptr,
    input logic [PTR_W-1:0] dst_size,
    input logic             blk_done_p,
    input logic             abort_p,
    input logic             reg_we,
    input logic [31:0]      reg_wdata,
    input logic [31:0]      reg_rdata,
    input logic             irq
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (reg_rdata == 32'h0) && !irq);

    // R3
    unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (reg_rdata[31:24] == 8'h0) && (reg_rdata[15:8] == 8'h0));

    // R4
    src_end_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $rose(reg_rdata[7]) |-> $past(src_ptr == src_size));

    // R7
    dst_mid_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $rose(reg_rdata[4]) |-> $past(dst_ptr == (dst_size >> 1)));

    // R9
    block_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        blk_done_p |=> reg_rdata[3]);

    // R9
    abort_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        abort_p |=> reg_rdata[1]);

    // R11
    enable_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(reg_we) |-> $stable(reg_rdata[23:16]));

    // R12
    irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> irq == $past(|(reg_rdata[23:16] & reg_rdata[7:0])));

    for (genvar i = 0; i < 8; i++) begin : g_flag
        // R10
        flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) && $past(reg_rdata[i]) && !$past(reg_we) |-> reg_rdata[i]);

        // R10
        flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) && $past(reg_rdata[i] && reg_we && reg_wdata[i]) |-> reg_rdata[i]);
    end

endmodule

bind dma_evt_irq dma_evt_irq_chk #(.PTR_W(PTR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .src_ptr    (src_ptr),
    .src_size   (src_size),
    .dst_ptr    (dst_ptr),
    .dst_size   (dst_size),
    .blk_done_p (blk_done_p),
    .abort_p    (abort_p),
    .reg_we     (reg_we),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .irq        (irq)
);

// File: tb/test_dma_evt_irq.sv
module test_dma_evt_irq;

    localparam int PTR_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [PTR_W-1:0] src_ptr = 16'd1;
    logic [PTR_W-1:0] src_size = 16'd100;
    logic [PTR_W-1:0] dst_ptr = 16'd1;
    logic [PTR_W-1:0] dst_size = 16'd64;
    logic             blk_done_p = 1'b0;
    logic             cell_done_p = 1'b0;
    logic             abort_p = 1'b0;
    logic             addr_err_p = 1'b0;
    logic             reg_we = 1'b0;
    logic [31:0]      reg_wdata = 32'h0;
    logic [31:0]      reg_rdata;
    logic             irq;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    dma_evt_irq #(.PTR_W(PTR_W)) i_dma_evt_irq (
        .clk         (clk),
        .rst         (rst),
        .src_ptr     (src_ptr),
        .src_size    (src_size),
        .dst_ptr     (dst_ptr),
        .dst_size    (dst_size),
        .blk_done_p  (blk_done_p),
        .cell_done_p (cell_done_p),
        .abort_p     (abort_p),
        .addr_err_p  (addr_err_p),
        .reg_we      (reg_we),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .irq         (irq)
    );

    initial forever #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Behavioural reference model, advanced at each rising edge.
    logic [7:0] m_flag = 8'h0;
    logic [7:0] m_en   = 8'h0;
    logic       m_irq  = 1'b0;
    logic [3:0] m_prev = 4'h0;

    always @(posedge clk) begin
        logic [3:0] cond;
        logic [7:0] setv;
        logic       nirq;
        if (rst) begin
            m_flag = 8'h0;
            m_en   = 8'h0;
            m_irq  = 1'b0;
            m_prev = 4'h0;
        end else begin
            cond[3] = (src_ptr == src_size);
            cond[2] = (src_ptr == src_size / 2);
            cond[1] = (dst_ptr == dst_size);
            cond[0] = (dst_ptr == dst_size / 2);
            setv = {cond & ~m_prev, blk_done_p, cell_done_p, abort_p, addr_err_p};
            m_prev = cond;
            nirq = (m_flag & m_en) != 8'h0;
            if (reg_we) begin
                m_flag = m_flag & reg_wdata[7:0];
                m_en   = reg_wdata[23:16];
            end
            m_flag = m_flag | setv;
            m_irq  = nirq;
        end
        #2;
        if (!finished) begin
            chk("R2 model register image", reg_rdata, {8'h0, m_en, 8'h0, m_flag});
            chk("R12 model request", {31'h0, irq}, {31'h0, m_irq});
        end
    end

    task automatic wr(input logic [31:0] d);
        reg_we = 1'b1;
        reg_wdata = d;
        step(1);
        reg_we = 1'b0;
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        // R1
        chk("R1 reset image", reg_rdata, 32'h0);
        chk("R1 reset irq", {31'h0, irq}, 32'h0);

        // R3 and R11: write all ones
        wr(32'hFFFF_FFFF);
        chk("R3 R11 all-ones write", reg_rdata, 32'h00FF_0000);

        // R5
        src_ptr = 16'd50;
        step(1);
        chk("R5 source middle", reg_rdata, 32'h00FF_0040);
        step(1);
        chk("R12 request raised", {31'h0, irq}, 32'h1);

        // R8: clear while comparison stays true
        wr(32'h00FF_00BF);
        chk("R8 cleared", reg_rdata, 32'h00FF_0000);
        step(3);
        chk("R8 no retrigger", reg_rdata, 32'h00FF_0000);

        // R4, R7, R6
        src_ptr = 16'd100;
        step(1);
        chk("R4 source end", reg_rdata, 32'h00FF_0080);
        dst_ptr = 16'd32;
        step(1);
        chk("R7 destination middle", reg_rdata, 32'h00FF_0090);
        dst_ptr = 16'd64;
        step(1);
        chk("R6 destination end", reg_rdata, 32'h00FF_00B0);

        // R9
        blk_done_p = 1'b1; step(1); blk_done_p = 1'b0;
        chk("R9 block pulse", reg_rdata, 32'h00FF_00B8);
        cell_done_p = 1'b1; step(1); cell_done_p = 1'b0;
        chk("R9 cell pulse", reg_rdata, 32'h00FF_00BC);
        abort_p = 1'b1; step(1); abort_p = 1'b0;
        chk("R9 abort pulse", reg_rdata, 32'h00FF_00BE);
        addr_err_p = 1'b1; step(1); addr_err_p = 1'b0;
        chk("R9 address error pulse", reg_rdata, 32'h00FF_00BF);

        // R10, R11: clear everything
        wr(32'h0);
        chk("R10 clear all", reg_rdata, 32'h0);
        step(1);
        chk("R12 request dropped", {31'h0, irq}, 32'h0);

        // R12 masking
        abort_p = 1'b1; step(1); abort_p = 1'b0;
        chk("R12 masked flag", reg_rdata, 32'h0000_0002);
        step(2);
        chk("R12 masked request", {31'h0, irq}, 32'h0);

        // R10: set wins over clear
        addr_err_p = 1'b1;
        wr(32'h00FF_0000);
        addr_err_p = 1'b0;
        chk("R10 set beats clear", reg_rdata, 32'h00FF_0001);
        wr(32'h00FF_0003);
        chk("R10 write one keeps", reg_rdata, 32'h00FF_0001);

        // Random phase, checked by the model every clock.
        for (int c = 0; c < 3000; c++) begin
            src_size    = 16'($urandom_range(0, 12));
            dst_size    = 16'($urandom_range(0, 12));
            src_ptr     = 16'($urandom_range(0, 12));
            dst_ptr     = 16'($urandom_range(0, 12));
            blk_done_p  = ($urandom_range(0, 5) == 0);
            cell_done_p = ($urandom_range(0, 5) == 0);
            abort_p     = ($urandom_range(0, 5) == 0);
            addr_err_p  = ($urandom_range(0, 5) == 0);
            reg_we      = ($urandom_range(0, 7) == 0);
            reg_wdata   = $urandom;
            if ($urandom_range(0, 63) == 0) rst = 1'b1;
            else rst = 1'b0;
            step(1);
        end
        rst = 1'b0;
        reg_we = 1'b0;
        step(2);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1;
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule